// File: doc/BRIEF.md
# Preamble-Locked Frame Capture Register

This block accepts a stream of already-decoded bits, each marked by a one-cycle strobe, and collects them in a single shift register one bit wider than a frame. While the block is hunting, the register serves as a sliding window that is compared against a fixed preamble pattern. When the window matches, the same register is cleared to a lone marker bit and then collects the payload frame. Once that marker has travelled to the top position, the frame is complete, further strobes are ignored, and a full flag is raised.

The preamble and the payload have the same length, so one buffer serves both phases. After capture, a 4-bit address selects one byte of the payload fields, which appears on an 8-bit read port. A halt input blocks bit intake at any time. A synchronous reset returns the block to hunting.

Top module: `fcap_frame_capture`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register is cleared to zero, `full` and `synced` go low, and `rd_data` reads 0x00 from the next edge onward.
- R2: A strobe (`bit_valid` high, `halt` low, `full` low) shifts `bit_in` into bit 0 of the register, and every older bit moves up one place. With no strobe, the register holds its value.
- R3: While `halt` is high, a strobe has no effect on the register, on `synced` or on `full`.
- R4: While hunting, if the 96 newest bits after a strobe equal the preamble (default: bit 95 is 1 and then alternates, so odd bits are 1 and even bits are 0, with bit 95 received first), then at that same edge the register becomes the value 1 and `synced` goes high.
- R5: After the reload, the 96th accepted strobe carries the marker into bit 96. `full` then goes high at that edge and stays high until reset, and the register ignores any further strobes.
- R6: In the captured frame, the bit received first sits at bit 95. The fields from the top down are: identifier in bits 95:64, room temperature in 63:48, set temperature in 47:32, state byte in 31:24, and tail bytes one, two and three in 23:16, 15:8 and 7:0.
- R7: With `full` high, addresses 0 to 3 return the identifier bytes starting with the least significant. Addresses 4 and 5 return the room temperature bytes and addresses 6 and 7 the set temperature bytes, in each case low byte first. Address 8 returns the state byte.
- R8: With `full` high, addresses 9, 10 and 11 return tail bytes one, two and three, and addresses 12 to 15 return 0x00.
- R9: While `full` is low, `rd_data` is 0x00 at every address.
- R10: A reset asserted in the middle of a capture discards the partial frame. The block then needs a fresh preamble before it captures again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Decoded data bit |
| bit_valid | input | 1 | One-cycle strobe qualifying `bit_in` |
| halt | input | 1 | Blocks bit intake while high |
| rd_addr | input | 4 | Byte select for the read port |
| rd_data | output | 8 | Selected byte of the captured frame |
| full | output | 1 | Frame complete; intake frozen |
| synced | output | 1 | Preamble seen; capturing or complete |

## Verification
Most faults in this block stay hidden until the frame completes. A register bit dropped, a shift taken twice or a lost strobe does not show at the ports while hunting or filling. It appears as a wrong `full` timing or as wrong bytes on the address sweep that follows the 96th payload bit. A missed or early preamble match shows on `synced` in the very cycle of the offending strobe. The reference model compares `synced`, `full` and `rd_data` on every cycle. It sweeps all sixteen addresses after each capture, so any of these faults shows up within one frame time.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

    localparam int ID_W    = 32;
    localparam int TEMP_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int TAIL_N  = 3;
    localparam int ADDR_W  = 4;
    localparam int FRAME_W = ID_W + 2 * TEMP_W + BYTE_W + TAIL_N * BYTE_W;

    typedef enum logic [1:0] {
        MODE_HUNT = 2'd0,
        MODE_FILL = 2'd1,
        MODE_DONE = 2'd2
    } cap_mode_e;

    // First received bit lands in the top of this struct.
    typedef struct packed {
        logic [ID_W-1:0]   ident;
        logic [TEMP_W-1:0] room;
        logic [TEMP_W-1:0] setp;
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] tail1;
        logic [BYTE_W-1:0] tail2;
        logic [BYTE_W-1:0] tail3;
    } frame_t;

    function automatic logic [FRAME_W-1:0] alt_pattern();
        logic [FRAME_W-1:0] p;
        for (int i = 0; i < FRAME_W; i++) begin
            p[i] = (i % 2) == 1;
        end
        return p;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(frame_t f, logic [ADDR_W-1:0] a);
        logic [BYTE_W-1:0] b;
        case (a)
            4'd0:    b = f.ident[7:0];
            4'd1:    b = f.ident[15:8];
            4'd2:    b = f.ident[23:16];
            4'd3:    b = f.ident[31:24];
            4'd4:    b = f.room[7:0];
            4'd5:    b = f.room[15:8];
            4'd6:    b = f.setp[7:0];
            4'd7:    b = f.setp[15:8];
            4'd8:    b = f.status;
            4'd9:    b = f.tail1;
            4'd10:   b = f.tail2;
            4'd11:   b = f.tail3;
            default: b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/fcap_match.sv
module fcap_match
    import fcap_pkg::*;
#(
    parameter int                 WIDTH   = FRAME_W,
    parameter logic [WIDTH-1:0]   PATTERN = alt_pattern()
) (
    input  logic [WIDTH-1:0] window,
    output logic             hit
);
    localparam int CHUNK  = 8;
    localparam int NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;

    logic [NCHUNK-1:0] chunk_eq;

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        localparam int LO = c * CHUNK;
        localparam int HI = ((LO + CHUNK) > WIDTH) ? WIDTH - 1 : LO + CHUNK - 1;
        assign chunk_eq[c] = (window[HI:LO] == PATTERN[HI:LO]);
    end

    assign hit = &chunk_eq;

endmodule

// File: rtl/fcap_shift.sv
module fcap_shift
    import fcap_pkg::*;
#(
    parameter int                 WIDTH   = FRAME_W,
    parameter logic [WIDTH-1:0]   PATTERN = alt_pattern()
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_in,
    input  logic            take,
    output logic [WIDTH:0]  shreg,
    output cap_mode_e       mode
);
    logic [WIDTH:0] nxt;
    logic           pre_hit;

    assign nxt = {shreg[WIDTH-1:0], bit_in};

    fcap_match #(.WIDTH(WIDTH), .PATTERN(PATTERN)) u_match (
        .window (nxt[WIDTH-1:0]),
        .hit    (pre_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            mode  <= MODE_HUNT;
        end else if (take) begin
            case (mode)
                MODE_HUNT: begin
                    if (pre_hit) begin
                        shreg <= {{WIDTH{1'b0}}, 1'b1};
                        mode  <= MODE_FILL;
                    end else begin
                        shreg <= nxt;
                    end
                end
                MODE_FILL: begin
                    shreg <= nxt;
                    if (nxt[WIDTH]) begin
                        mode <= MODE_DONE;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/fcap_read.sv
module fcap_read
    import fcap_pkg::*;
(
    input  frame_t              frame,
    input  logic                valid,
    input  logic [ADDR_W-1:0]   addr,
    output logic [BYTE_W-1:0]   data
);
    always_comb begin
        data = valid ? pick_byte(frame, addr) : '0;
    end

endmodule

// File: rtl/fcap_frame_capture.sv
module fcap_frame_capture
    import fcap_pkg::*;
#(
    parameter logic [FRAME_W-1:0] PREAMBLE = alt_pattern()
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_valid,
    input  logic              halt,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              full,
    output logic              synced
);
    logic [FRAME_W:0] shreg;
    cap_mode_e        mode;
    logic             take;

    assign take = bit_valid & ~halt;

    fcap_shift #(.WIDTH(FRAME_W), .PATTERN(PREAMBLE)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .bit_in (bit_in),
        .take   (take),
        .shreg  (shreg),
        .mode   (mode)
    );

    assign full   = (mode == MODE_DONE);
    assign synced = (mode != MODE_HUNT);

    fcap_read u_read (
        .frame (frame_t'(shreg[FRAME_W-1:0])),
        .valid (full),
        .addr  (rd_addr),
        .data  (rd_data)
    );

endmodule

// File: rtl/fcap_checker.sv
module fcap_checker
    import fcap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bit_valid,
    input logic              halt,
    input logic              full,
    input logic              synced,
    input logic [FRAME_W:0]  shreg,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [BYTE_W-1:0] rd_data
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!full && !synced && shreg == '0)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(shreg)); // R2

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        halt |=> ($stable(shreg) && $stable(synced) && $stable(full))); // R3

    AST_RELOAD_ONE: assert property (@(posedge clk) disable iff (rst)
        $rose(synced) |-> (shreg == {{FRAME_W{1'b0}}, 1'b1})); // R4

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
        full |=> full); // R5

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        full |=> $stable(shreg)); // R5

    AST_FULL_MARKER: assert property (@(posedge clk) disable iff (rst)
        full |-> (shreg[FRAME_W] && synced)); // R5

    AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr[3:2] == 2'b11) |-> (rd_data == '0)); // R8

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !full |-> (rd_data == '0)); // R9

endmodule

bind fcap_frame_capture fcap_checker u_fcap_checker (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .halt      (halt),
    .full      (full),
    .synced    (synced),
    .shreg     (shreg),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/test_fcap_frame_capture.sv
module test_fcap_frame_capture;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic       halt = 1'b0;
    logic [3:0] rd_addr = 4'd0;
    logic [7:0] rd_data;
    logic       full;
    logic       synced;

    int    vectors = 0;
    int    fails   = 0;
    int    cycles  = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    fcap_frame_capture i_fcap_frame_capture (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .halt      (halt),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .full      (full),
        .synced    (synced)
    );

    // ---------------- reference model ----------------
    int          m_mode = 0;          // 0 hunting, 1 filling, 2 complete
    logic [95:0] m_hist = '0;
    logic [95:0] m_pre;
    bit          m_cap[$];

    initial begin
        for (int i = 0; i < 96; i++) m_pre[i] = (i % 2) == 1;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0;
            m_hist = '0;
            m_cap.delete();
        end else if (bit_valid && !halt) begin
            if (m_mode == 0) begin
                m_hist = {m_hist[94:0], bit_in};
                if (m_hist == m_pre) begin
                    m_mode = 1;
                    m_cap.delete();
                end
            end else if (m_mode == 1) begin
                m_cap.push_back(bit_in);
                if (m_cap.size() == 96) m_mode = 2;
            end
        end
    end

    // Frame bit k (0 = newest) is the (95-k)th bit received.
    function automatic logic [7:0] exp_byte(int a);
        int off;
        logic [7:0] b;
        b = '0;
        if (m_mode != 2) return b;
        case (a)
            0: off = 64;  1: off = 72;  2: off = 80;  3: off = 88;
            4: off = 48;  5: off = 56;  6: off = 32;  7: off = 40;
            8: off = 24;  9: off = 16;  10: off = 8;  11: off = 0;
            default: return b;
        endcase
        for (int j = 0; j < 8; j++) b[j] = m_cap[95 - (off + j)];
        return b;
    endfunction

    always @(negedge clk) begin
        logic [7:0] eb;
        logic       ef;
        logic       es;
        eb = exp_byte(int'(rd_addr));
        ef = (m_mode == 2);
        es = (m_mode != 0);
        vectors++;
        if (rd_data !== eb || full !== ef || synced !== es) begin
            fails++;
            $display("FAIL %s addr=%0d actual data=%02h full=%b synced=%b expected data=%02h full=%b synced=%b",
                     cur_req, rd_addr, rd_data, full, synced, eb, ef, es);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic send_bit(input logic b, input logic h);
        bit_in    = b;
        bit_valid = 1'b1;
        halt      = h;
        tick();
        bit_valid = 1'b0;
        halt      = 1'b0;
    endtask

    task automatic send_range(input logic [95:0] v, input int hi, input int lo, input int gap);
        for (int i = hi; i >= lo; i--) begin
            send_bit(v[i], 1'b0);
            if (gap > 0 && (i % gap) == 0) begin
                send_bit(~v[i], 1'b1);   // halted decoy, must be ignored (R3)
                tick();
            end
        end
    endtask

    task automatic sweep(input int lo, input int hi);
        for (int a = lo; a <= hi; a++) begin
            rd_addr = a[3:0];
            tick();
        end
    endtask

    localparam logic [95:0] FRAME_A = {32'hC0FF_EE42, 16'h0123, 16'hBEEF, 8'h5A, 8'h11, 8'h22, 8'h33};
    localparam logic [95:0] FRAME_B = {32'h8BAD_F00D, 16'h7FFF, 16'h8000, 8'hA5, 8'h00, 8'hFF, 8'h81};

    initial begin
        logic [95:0] pre;
        for (int i = 0; i < 96; i++) pre[i] = (i % 2) == 1;

        // R1: reset state
        cur_req = "R1";
        tick(); tick(); tick();
        rst = 1'b0;
        sweep(0, 15);

        // R2: noise bits while hunting
        cur_req = "R2";
        for (int i = 0; i < 40; i++) send_bit(((i / 3) % 2) == 0, 1'b0);
        tick();

        // R3: halted strobes carrying the last preamble bit must not lock
        cur_req = "R3";
        send_range(pre, 95, 1, 0);
        send_bit(pre[0], 1'b1);
        send_bit(pre[0], 1'b1);
        tick();

        // R4: real preamble, with halted decoys interleaved
        cur_req = "R4";
        send_range(pre, 95, 0, 7);
        tick();

        // R9: read port stays zero while the frame fills
        cur_req = "R9";
        send_range(FRAME_A, 95, 48, 11);
        sweep(0, 15);
        send_range(FRAME_A, 47, 1, 0);

        // R5: final bit sets full, later strobes ignored
        cur_req = "R5";
        send_range(FRAME_A, 0, 0, 0);
        for (int i = 0; i < 20; i++) send_bit(i[0], 1'b0);

        // R6/R7: field layout and low address bytes
        cur_req = "R7";
        sweep(0, 8);
        cur_req = "R6";
        sweep(0, 3);
        // R8: tails and empty addresses
        cur_req = "R8";
        sweep(9, 15);

        // R10: reset mid-capture, then a fresh lock and frame
        cur_req = "R10";
        rst = 1'b1; tick(); rst = 1'b0;
        send_range(pre, 95, 0, 0);
        send_range(FRAME_B, 95, 66, 0);
        rst = 1'b1; tick(); rst = 1'b0;
        send_range(FRAME_B, 95, 0, 0);   // no preamble: must not capture
        sweep(0, 15);
        send_range(pre, 95, 0, 0);
        send_range(FRAME_B, 95, 0, 0);
        cur_req = "R6";
        sweep(0, 15);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule